// File: doc/BRIEF.md
# DRAM Bank Timing and Refresh Sequencer

This block is the control core of an external DRAM controller. Requests arrive on a simple valid/ready port and are decoded into one of four 8 MB banks. A request to a bank that software has not enabled, or into the reserved space above the four banks, is rejected with an error response. An accepted request then runs through a small access machine: a setup phase, an access phase whose read length is the bank's data latency, and a recovery phase in idle. All three lengths come from a per-bank timing register.

A microsecond prescaler paces a refresh timer whose period is programmed in whole microseconds. A pending refresh takes priority over any waiting request. Setting the power-save bit turns the next refresh into a self-refresh entry, and the memory stays there until software clears the bit. For device initialisation, software writes a per-bank raw command register. Each such write drives the stored address and strobe levels onto the memory pins for exactly one clock.

Top module: `dram_seq_core`

## Requirements
- R1: The configuration port is 16 bits wide and is selected by `cfg_sel`: values 0..3 pick a bank timing register, 4..7 a bank raw address register, 8..11 a bank raw strobe register, 12 the global register, and every other value is ignored. The bank timing register fields are: [1:0] device width (0 = 8-bit, 1 = 16-bit, 2 = 32-bit), [3:2] read latency, [6:4] setup, [9:7] idle, [11:10] column width (0 = 8, 1 = 9, 2 = 10, 3 treated as 10 bits). The global register fields are: [7:0] refresh period, [11:8] one enable bit per bank, [12] type (1 = SDRAM, 0 = EDO), [13] power-save.
- R2: The bank is `req_addr[24:23]`. Bit 25 marks the reserved region. During the access phase only that bank's chip select is low, and at most one chip select is ever low outside a refresh.
- R3: A request to a disabled bank, or with bit 25 set, gets `resp_valid` and `resp_err` together one cycle after acceptance. No chip select is driven for it, and the next request can be accepted in the following cycle.
- R4: For a read, the access phase starts `setup` cycles after acceptance and lasts `latency + 1` cycles. `resp_valid` therefore appears `setup + latency + 1` cycles after the accepting edge.
- R5: A write ignores latency. It responds `setup + 1` cycles after acceptance, with `mem_we_n` low during the access.
- R6: After an access response, `req_ready` stays low until `idle + 1` cycles have passed.
- R7: The address on `mem_addr` during the access is the in-bank byte offset, shifted right by 0, 1 or 2 according to the device width, and masked to the column width.
- R8: With refresh period N > 0, a refresh command is issued every N × CLK_PER_US clocks while the machine is idle. N = 0 issues none. A refresh drives all chip selects low, `mem_cas_n` low and `mem_we_n` high. `mem_ras_n` is low for SDRAM and high for EDO (CAS-before-RAS).
- R9: A pending refresh is issued at the next ready idle cycle, ahead of a waiting request. `req_ready` is low while the refresh is pending.
- R10: With power-save set, the next refresh drives `mem_cke` low. `mem_cke` stays low and `req_ready` stays low until power-save is cleared, after which requests are served again.
- R11: A write to a raw strobe register drives, in the next cycle only, that bank's chip select low and `mem_ras_n`, `mem_cas_n` and `mem_we_n` from data bits 0, 1 and 2. In the same cycle it drives the bank's raw address register onto `mem_addr`.
- R12: After reset all banks are disabled, refresh is off, `req_ready` is high, every chip select and strobe is high, and `mem_cke` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_data | input | 16 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | ADDR_W | Request byte address |
| req_ready | output | 1 | Request accepted at this edge if valid |
| resp_valid | output | 1 | Access finished or rejected |
| resp_err | output | 1 | Rejected request |
| mem_cs_n | output | 4 | Per-bank chip selects |
| mem_ras_n | output | 1 | Row strobe |
| mem_cas_n | output | 1 | Column strobe |
| mem_we_n | output | 1 | Write enable |
| mem_cke | output | 1 | Clock enable, low in self-refresh |
| mem_addr | output | MA_W | Memory address |

## Verification
The bench sweeps every combination of setup, latency and idle for both reads and writes. For each one it measures response timing, the recovery gap and the pins in the access cycle. An off-by-one in any counter would shift one of these measured cycle counts by one.

Rejected requests are checked for having no chip-select activity and no recovery gap. A controller that ran an access for them, or charged idle time, would fail here. Refresh spacing is measured between consecutive commands, so a prescaler or period boundary error changes the interval. The bench also checks that a refresh is inserted between back-to-back accesses. The raw command is checked to last exactly one cycle, and self-refresh is checked to hold `mem_cke` low until power-save is cleared.

// File: rtl/dram_seq_core.sv
module dram_seq_core #(
  parameter int CLK_PER_US = 100,
  parameter int ADDR_W     = 26,
  parameter int MA_W       = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_sel,
  input  logic [15:0]       cfg_data,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [3:0]        mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic              mem_cke,
  output logic [MA_W-1:0]   mem_addr
);
  localparam int OFF_W = ADDR_W - 3;
  localparam int PRE_W = $clog2(CLK_PER_US + 1);

  typedef enum logic [2:0] {S_IDLE = 3'd0, S_DEC = 3'd1, S_ACC = 3'd2,
                            S_REF = 3'd3, S_SELF = 3'd4} st_t;

  logic [11:0]     bcfg  [4];
  logic [MA_W-1:0] rawlo [4];
  logic [7:0]      g_period;
  logic [3:0]      g_ben;
  logic            g_sdram, g_pws;
  logic            raw_go;
  logic [1:0]      raw_bank;
  logic [2:0]      raw_cmd;

  st_t             st;
  logic [2:0]      cnt, idle_cnt;
  logic [1:0]      cur_bank;
  logic            cur_wr;
  logic [MA_W-1:0] cur_col;
  logic            err_q;
  logic            ref_pend;
  logic [PRE_W-1:0] pre;
  logic [7:0]      us_cnt;

  logic unused_cfg;
  assign unused_cfg = ^cfg_data[15:14];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        bcfg[i]  <= '0;
        rawlo[i] <= '0;
      end
      g_period <= '0;
      g_ben    <= '0;
      g_sdram  <= 1'b0;
      g_pws    <= 1'b0;
      raw_go   <= 1'b0;
      raw_bank <= '0;
      raw_cmd  <= '1;
    end else begin
      raw_go <= 1'b0;
      if (cfg_we) begin
        case (cfg_sel[3:2])
          2'b00: bcfg[cfg_sel[1:0]]  <= cfg_data[11:0];
          2'b01: rawlo[cfg_sel[1:0]] <= cfg_data[MA_W-1:0];
          2'b10: begin
            raw_go   <= 1'b1;
            raw_bank <= cfg_sel[1:0];
            raw_cmd  <= cfg_data[2:0];
          end
          default: if (cfg_sel[1:0] == 2'b00) begin
            g_period <= cfg_data[7:0];
            g_ben    <= cfg_data[11:8];
            g_sdram  <= cfg_data[12];
            g_pws    <= cfg_data[13];
          end
        endcase
      end
    end
  end

  // request decode and column address
  logic [1:0]       rq_bank;
  logic             rq_bad;
  logic [11:0]      rq_cfg;
  logic [1:0]       rq_sh;
  logic [3:0]       rq_cw;
  logic [OFF_W-1:0] rq_off, rq_mask;
  logic [MA_W-1:0]  rq_col;

  assign rq_bank = req_addr[OFF_W +: 2];
  assign rq_bad  = req_addr[ADDR_W-1] | ~g_ben[rq_bank];
  assign rq_cfg  = bcfg[rq_bank];

  always_comb begin
    case (rq_cfg[1:0])
      2'd0:    rq_sh = 2'd0;
      2'd1:    rq_sh = 2'd1;
      default: rq_sh = 2'd2;
    endcase
    rq_cw   = (rq_cfg[11:10] == 2'd3) ? 4'd10 : 4'd8 + {2'b00, rq_cfg[11:10]};
    rq_off  = req_addr[OFF_W-1:0] >> rq_sh;
    rq_mask = (OFF_W'(1) << rq_cw) - OFF_W'(1);
    rq_col  = MA_W'(rq_off & rq_mask);
  end

  // refresh timer
  logic us_tick, expire;
  assign us_tick = (pre == PRE_W'(CLK_PER_US - 1));
  assign expire  = (g_period != 8'd0) && us_tick && (us_cnt == g_period - 8'd1);

  always_ff @(posedge clk) begin
    if (!rst_n || g_period == 8'd0) begin
      pre    <= '0;
      us_cnt <= '0;
    end else if (us_tick) begin
      pre    <= '0;
      us_cnt <= expire ? 8'd0 : us_cnt + 8'd1;
    end else begin
      pre <= pre + PRE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ref_pend <= 1'b0;
    else        ref_pend <= (ref_pend && st != S_REF) || expire;
  end

  // access sequencer
  assign req_ready = (st == S_IDLE) && (idle_cnt == 3'd0) && !ref_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      idle_cnt <= '0;
      cur_bank <= '0;
      cur_wr   <= 1'b0;
      cur_col  <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (idle_cnt != 3'd0) idle_cnt <= idle_cnt - 3'd1;
          else if (ref_pend) st <= S_REF;
          else if (req_valid) begin
            if (rq_bad) err_q <= 1'b1;
            else begin
              cur_bank <= rq_bank;
              cur_wr   <= req_write;
              cur_col  <= rq_col;
              if (rq_cfg[6:4] == 3'd0) begin
                st  <= S_ACC;
                cnt <= req_write ? 3'd0 : {1'b0, rq_cfg[3:2]};
              end else begin
                st  <= S_DEC;
                cnt <= rq_cfg[6:4] - 3'd1;
              end
            end
          end
        end
        S_DEC: begin
          if (cnt == 3'd0) begin
            st  <= S_ACC;
            cnt <= cur_wr ? 3'd0 : {1'b0, bcfg[cur_bank][3:2]};
          end else cnt <= cnt - 3'd1;
        end
        S_ACC: begin
          if (cnt == 3'd0) begin
            st       <= S_IDLE;
            idle_cnt <= bcfg[cur_bank][9:7];
          end else cnt <= cnt - 3'd1;
        end
        S_REF:   st <= g_pws ? S_SELF : S_IDLE;
        S_SELF:  if (!g_pws) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign resp_valid = (st == S_ACC && cnt == 3'd0) || err_q;
  assign resp_err   = err_q;
  assign mem_cke    = !(st == S_SELF || (st == S_REF && g_pws));

  always_comb begin
    mem_cs_n  = 4'hF;
    mem_ras_n = 1'b1;
    mem_cas_n = 1'b1;
    mem_we_n  = 1'b1;
    mem_addr  = '0;
    if (raw_go) begin
      mem_cs_n  = ~(4'b0001 << raw_bank);
      mem_ras_n = raw_cmd[0];
      mem_cas_n = raw_cmd[1];
      mem_we_n  = raw_cmd[2];
      mem_addr  = rawlo[raw_bank];
    end else if (st == S_REF) begin
      mem_cs_n  = 4'h0;
      mem_ras_n = !g_sdram;
      mem_cas_n = 1'b0;
    end else if (st == S_ACC) begin
      mem_cs_n  = ~(4'b0001 << cur_bank);
      mem_ras_n = 1'b0;
      mem_cas_n = 1'b0;
      mem_we_n  = !cur_wr;
      mem_addr  = cur_col;
    end
  end
endmodule

// File: rtl/dram_seq_core_chk.sv
module dram_seq_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [3:0] cfg_sel,
  input logic [2:0] cfg_low,
  input logic       req_ready,
  input logic       resp_valid,
  input logic       resp_err,
  input logic [3:0] mem_cs_n,
  input logic       mem_ras_n,
  input logic       mem_cas_n,
  input logic       mem_we_n,
  input logic       mem_cke,
  input logic [2:0] st,
  input logic [2:0] idle_cnt,
  input logic       ref_pend,
  input logic       raw_go
);
  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n) || (mem_cs_n == 4'h0));

  // R3
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> (resp_valid && mem_cs_n == 4'hF));

  // R4
  resp_one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_err && !raw_go) |-> ($countones(~mem_cs_n) == 1));

  // R9
  ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pend && st == 3'd0 && idle_cnt == 3'd0 && !(cfg_we && cfg_sel[3:2] == 2'b10))
      |=> (mem_cs_n == 4'h0 && !mem_cas_n));

  // R10
  self_ref_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cke |-> !req_ready);

  // R11
  raw_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel[3:2] == 2'b10) |=>
      ({mem_we_n, mem_cas_n, mem_ras_n} == $past(cfg_low) && $countones(~mem_cs_n) == 1));
endmodule

bind dram_seq_core dram_seq_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_low(cfg_data[2:0]),
  .req_ready(req_ready), .resp_valid(resp_valid), .resp_err(resp_err),
  .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
  .mem_we_n(mem_we_n), .mem_cke(mem_cke), .st(st), .idle_cnt(idle_cnt),
  .ref_pend(ref_pend), .raw_go(raw_go));

// File: tb/dram_seq_core_tb.sv
module dram_seq_core_tb_top;
  localparam int CPU = 4;
  localparam int AW  = 26;
  localparam int MW  = 14;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_sel = 0;
  logic [15:0] cfg_data = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = 0;
  logic req_ready, resp_valid, resp_err, mem_ras_n, mem_cas_n, mem_we_n, mem_cke;
  logic [3:0] mem_cs_n;
  logic [MW-1:0] mem_addr;

  int total = 0, bad = 0;
  int ref_seen = 0;

  always #5 clk = ~clk;

  dram_seq_core #(.CLK_PER_US(CPU), .ADDR_W(AW), .MA_W(MW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_err(resp_err),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_cke(mem_cke), .mem_addr(mem_addr));

  always @(negedge clk) if (rst_n && mem_cs_n == 4'h0) ref_seen++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr_cfg(input int sel, input int data);
    cfg_we = 1; cfg_sel = 4'(sel); cfg_data = 16'(data);
    step();
    cfg_we = 0;
  endtask

  function automatic int gcfg(input int per, input int ben, input int sd, input int pws);
    return per | (ben << 8) | (sd << 12) | (pws << 13);
  endfunction

  function automatic int exp_col(input int off, input int dw, input int cw);
    int sh = (dw == 0) ? 0 : (dw == 1) ? 1 : 2;
    int bits = (cw == 3) ? 10 : 8 + cw;
    return (off >> sh) & ((1 << bits) - 1);
  endfunction

  // issue a request; returns cycles to response, error flag, pins at response, gap to ready
  task automatic txn(input int addr, input bit wr, output int n, output bit err,
                     output int cs, output bit we, output int col, output int gap);
    int w = 0;
    req_addr = AW'(addr); req_write = wr; req_valid = 1;
    while (!req_ready && w < 100) begin step(); w++; end
    n = 0;
    do begin step(); n++; end while (!resp_valid && n < 40);
    err = resp_err; cs = mem_cs_n; we = mem_we_n; col = mem_addr;
    gap = 0;
    while (!req_ready && gap < 40) begin step(); gap++; end
    req_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, cs, col, gap, r0, t0, prev, cnt;
    bit err, we;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(req_ready == 1, "R12 ready", req_ready, 1);
    chk(mem_cs_n == 4'hF && mem_ras_n && mem_cas_n && mem_we_n, "R12 pins", mem_cs_n, 15);
    chk(mem_cke == 1 && resp_valid == 0, "R12 cke", mem_cke, 1);
    txn(0, 0, n, err, cs, we, col, gap);
    chk(err == 1 && n == 1, "R12 banks disabled", n, 1);

    wr_cfg(12, gcfg(0, 15, 1, 0));
    // R4 R5 R6 R7 R1 sweep
    for (int s = 0; s < 8; s++)
      for (int l = 0; l < 4; l++)
        for (int i = 0; i < 8; i++)
          for (int w = 0; w < 2; w++) begin
            int b = (s + l) % 4;
            int dw = i % 3;
            int cw = (s + w) % 4;
            int off = (s * 97 + l * 1031 + i * 12345 + w * 7 + 3) & 32'h7FFFFF;
            wr_cfg(b, dw | (l << 2) | (s << 4) | (i << 7) | (cw << 10));
            txn((b << 23) | off, w[0], n, err, cs, we, col, gap);
            if (w == 0) chk(n == s + l + 1 && !err, "R4 read latency", n, s + l + 1);
            else        chk(n == s + 1 && !err, "R5 write latency", n, s + 1);
            chk(cs == (15 & ~(1 << b)), "R2 bank select", cs, 15 & ~(1 << b));
            chk(we == !w[0], "R5 write strobe", we, !w[0]);
            chk(col == exp_col(off, dw, cw), "R7 column", col, exp_col(off, dw, cw));
            chk(gap == i + 1, "R6 idle gap", gap, i + 1);
          end

    // R3 disabled bank and reserved region
    wr_cfg(12, gcfg(0, 4'b1011, 1, 0));
    txn(2 << 23, 0, n, err, cs, we, col, gap);
    chk(n == 1 && err, "R3 disabled latency", n, 1);
    chk(cs == 15, "R3 no select", cs, 15);
    chk(gap == 0, "R3 no idle", gap, 0);
    txn((1 << 25) | 5, 1, n, err, cs, we, col, gap);
    chk(n == 1 && err, "R3 reserved region", n, 1);
    txn(1 << 23, 0, n, err, cs, we, col, gap);
    chk(!err, "R3 enabled bank ok", err, 0);

    // R1 ignored select value
    wr_cfg(13, gcfg(0, 0, 1, 0));
    txn(1 << 23, 0, n, err, cs, we, col, gap);
    chk(!err, "R1 select 13 ignored", err, 0);

    // R11 raw command
    wr_cfg(5, 16'h3ABC);
    wr_cfg(9, 3'b101);
    chk(mem_cs_n == 4'b1101, "R11 raw select", mem_cs_n, 13);
    chk({mem_we_n, mem_cas_n, mem_ras_n} == 3'b101, "R11 raw strobes",
        {mem_we_n, mem_cas_n, mem_ras_n}, 5);
    chk(mem_addr == 14'h3ABC, "R11 raw address", mem_addr, 14'h3ABC);
    step();
    chk(mem_cs_n == 4'hF && mem_cas_n, "R11 one cycle", mem_cs_n, 15);

    // R8 refresh interval, SDRAM
    wr_cfg(12, gcfg(3, 15, 1, 0));
    prev = -1; cnt = 0;
    for (int c = 0; c < 80 && cnt < 4; c++) begin
      if (mem_cs_n == 4'h0) begin
        chk(!mem_ras_n && !mem_cas_n && mem_we_n, "R8 sdram command", mem_ras_n, 0);
        if (prev >= 0) chk(c - prev == 3 * CPU, "R8 interval", c - prev, 3 * CPU);
        prev = c; cnt++;
      end
      step();
    end
    chk(cnt == 4, "R8 refresh count", cnt, 4);
    // EDO command shape
    wr_cfg(12, gcfg(2, 15, 0, 0));
    t0 = 0;
    while (mem_cs_n != 4'h0 && t0 < 40) begin step(); t0++; end
    chk(mem_ras_n && !mem_cas_n && mem_we_n, "R8 edo command", mem_ras_n, 1);
    // period zero
    wr_cfg(12, gcfg(0, 15, 1, 0));
    step();
    r0 = ref_seen;
    repeat (60) step();
    chk(ref_seen == r0, "R8 disabled", ref_seen - r0, 0);

    // R9 refresh before waiting request
    wr_cfg(0, (3 << 2) | (7 << 4));
    wr_cfg(12, gcfg(1, 15, 1, 0));
    txn(0, 0, n, err, cs, we, col, gap);
    for (int k = 0; k < 3; k++) begin
      r0 = ref_seen;
      txn(0, 0, n, err, cs, we, col, gap);
      chk(ref_seen > r0, "R9 refresh inserted", ref_seen - r0, 1);
    end

    // R10 self-refresh
    wr_cfg(12, gcfg(2, 15, 1, 1));
    t0 = 0;
    while (mem_cke && t0 < 40) begin step(); t0++; end
    chk(!mem_cke && mem_cs_n == 4'h0, "R10 entry on refresh", mem_cs_n, 0);
    repeat (30) step();
    chk(!mem_cke && !req_ready, "R10 held", mem_cke, 0);
    wr_cfg(12, gcfg(0, 15, 1, 0));
    step();
    chk(mem_cke == 1, "R10 exit", mem_cke, 1);
    txn(0, 1, n, err, cs, we, col, gap);
    chk(!err && n == 8, "R10 served after exit", n, 8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule